// File: doc/BRIEF.md
# Status Register Write-Protect Unit

This unit holds the protection-related fields of a serial flash status register and decides whether a status-register write may change them. It holds a lock bit, a quad-enable bit and a four-bit block-protect field. It also keeps a write-enable latch that the command decoder sets and clears.

A write request carries a full new status byte. The request is committed only if two conditions hold: the write-enable latch is set, and hardware protection is not in force. Hardware protection is in force only when the stored lock bit is 1, the external active-low write-protect pin is low and quad mode is off. When quad mode is on, the pin serves as a data line, so it counts as released.

A refused request leaves every stored bit as it was and raises a one-cycle error pulse. Every request, accepted or refused, clears the write-enable latch. The pin is resynchronised to the core clock before it is used.

Top module: `sreg_guard`

## Requirements
- R1: While rst_n is low at a rising clock edge, all of the following are zero after that edge: the status readback (lock, quad-enable, block-protect), the write-enable latch and wr_err.
- R2: The status readback is laid out as [7] lock, [6] quad-enable, [5:2] block-protect and [1] write-enable latch, with [0] always zero. A cycle with wen_cmd sets bit 1 and a cycle with wdis_cmd clears it. When both commands arrive together, wdis_cmd wins.
- R3: An accepted request copies sr_wdata[7:2] into bits [7:2] of the readback at the same clock edge. sr_wdata[1:0] have no effect.
- R4: A request made while the write-enable latch is clear is refused. Bits [7:2] stay unchanged and wr_err is 1 for the cycle after that edge.
- R5: Every request clears the write-enable latch at its edge, whether it is accepted or refused. This holds even when wen_cmd arrives in the same cycle, and the request is judged by the latch value held before that edge.
- R6: With lock=1, quad-enable=0 and the synchronised pin low, a request is refused with wr_err, even when the latch is set.
- R7: With lock=1 and the synchronised pin high, a request with the latch set is accepted.
- R8: With lock=0, a request with the latch set is accepted whatever the pin level.
- R9: With quad-enable=1, the pin level is ignored, and a request with the latch set is accepted even when lock=1 and the pin is low.
- R10: The pin passes through a two-flop synchroniser that resets to the released (high) level. A pin change first affects a request at the third rising edge after the change.
- R11: wr_err stays high for only one cycle after a single refused request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wen_cmd | input | 1 | Write-enable command strobe |
| wdis_cmd | input | 1 | Write-disable command strobe |
| sr_wr_req | input | 1 | Status-register write request strobe |
| sr_wdata | input | 8 | New status byte for the request |
| wp_pin_n | input | 1 | Asynchronous active-low write-protect pin |
| sr_rdata | output | 8 | Status readback |
| wr_err | output | 1 | One-cycle pulse after a refused request |

## Verification
The bench goes after the synchroniser delay: it changes the pin, then places a request two edges later. A design that used the pin one stage early would accept that write when it should refuse it.

The bench also checks that quad mode overrides the pin. A design that ignored quad-enable would lock itself, so the lock could not be cleared while the pin is low.

Two more cases target the latch. A request sent together with wen_cmd while the latch is clear must still be refused. A design that let the set command win would keep the latch alive for the next write.

A last case sets the lock while the pin is already low, from an unlocked state. That write must be accepted. A design that judged the request by the new data rather than by the stored lock would refuse it.

// File: rtl/sreg_guard_pkg.sv
// Package: shared field widths, bit positions and the stored protection type.
// Assumes an 8-bit status image with the protection fields in bits 7..2.
package sreg_guard_pkg;
    localparam int BP_W     = 4;
    localparam int SR_W     = BP_W + 4;
    localparam int POS_LOCK = SR_W - 1;
    localparam int POS_QEN  = SR_W - 2;
    localparam int POS_BPHI = SR_W - 3;
    localparam int POS_BPLO = 2;
    localparam int POS_WEL  = 1;

    typedef struct packed {
        logic            lock;
        logic            qen;
        logic [BP_W-1:0] bp;
    } prot_t;

    // Pick the writable fields out of a full status byte.
    function automatic prot_t unpack_prot(input logic [SR_W-1:0] b);
        prot_t p;
        p.lock = b[POS_LOCK];
        p.qen  = b[POS_QEN];
        p.bp   = b[POS_BPHI:POS_BPLO];
        return p;
    endfunction
endpackage

// File: rtl/sreg_pin_sync.sv
// Multi-flop synchroniser for an asynchronous active-low pin.
// Assumes STAGES >= 2. Resets to the released (high) level.
module sreg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= pin_n;
                end
            end else begin : g_next
                // Later stages shift the sampled value along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/sreg_wel.sv
// Write-enable latch: set by a command, cleared by a command or by any write attempt.
// Assumes an attempt takes priority over both commands, and clear over set.
module sreg_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_cmd,
    input  logic clr_cmd,
    input  logic attempt,
    output logic wel
);
    // Latch update with attempt > clear > set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel <= 1'b0;
        else if (attempt) wel <= 1'b0;
        else if (clr_cmd) wel <= 1'b0;
        else if (set_cmd) wel <= 1'b1;
    end
endmodule

// File: rtl/sreg_commit.sv
// Holds the protection fields and commits a request when the latch is set
// and hardware protection is not in force. A refused request raises a
// one-cycle error. Assumes wp_sync_n is already in the clock domain.
module sreg_commit
    import sreg_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req,
    input  prot_t wdata,
    input  logic  wel,
    input  logic  wp_sync_n,
    output prot_t prot,
    output logic  err
);
    logic pin_active;
    logic hw_locked;
    logic accept;

    // Decide protection from stored state and the synchronised pin.
    always_comb begin
        pin_active = ~wp_sync_n & ~prot.qen;
        hw_locked  = prot.lock & pin_active;
        accept     = req & wel & ~hw_locked;
    end

    // Stored protection fields.
    always_ff @(posedge clk) begin
        if (!rst_n)      prot <= '0;
        else if (accept) prot <= wdata;
    end

    // Error pulse for a refused request.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= req & ~accept;
    end
endmodule

// File: rtl/sreg_guard.sv
// Top: status-register write-protect unit. Synchronises the pin, keeps the
// write-enable latch and the protection fields, and forms the readback byte.
// Assumes command and request strobes are single-cycle and synchronous.
module sreg_guard
    import sreg_guard_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wen_cmd,
    input  logic            wdis_cmd,
    input  logic            sr_wr_req,
    input  logic [SR_W-1:0] sr_wdata,
    input  logic            wp_pin_n,
    output logic [SR_W-1:0] sr_rdata,
    output logic            wr_err
);
    logic  wp_sync_n;
    logic  wel;
    prot_t prot;

    sreg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (wp_pin_n),
        .sync_n (wp_sync_n)
    );

    sreg_wel u_wel (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_cmd (wen_cmd),
        .clr_cmd (wdis_cmd),
        .attempt (sr_wr_req),
        .wel     (wel)
    );

    sreg_commit u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (sr_wr_req),
        .wdata     (unpack_prot(sr_wdata)),
        .wel       (wel),
        .wp_sync_n (wp_sync_n),
        .prot      (prot),
        .err       (wr_err)
    );

    // Assemble the readback byte.
    always_comb begin
        sr_rdata                    = '0;
        sr_rdata[POS_LOCK]          = prot.lock;
        sr_rdata[POS_QEN]           = prot.qen;
        sr_rdata[POS_BPHI:POS_BPLO] = prot.bp;
        sr_rdata[POS_WEL]           = wel;
    end
endmodule

// File: rtl/sreg_guard_chk.sv
// Checker for sreg_guard, attached by bind. Relates requests, the latch,
// the synchronised pin and the error pulse over time.
module sreg_guard_chk
    import sreg_guard_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            wen_cmd,
    input logic            wdis_cmd,
    input logic            sr_wr_req,
    input logic [SR_W-1:0] sr_rdata,
    input logic            wr_err,
    input logic            wp_sync_n
);
    // R4: an error edge leaves the stored fields unchanged
    p_reject_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> sr_rdata[POS_LOCK:POS_BPLO] == $past(sr_rdata[POS_LOCK:POS_BPLO]));

    // R4: an error only follows a request
    p_err_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(sr_wr_req));

    // R5: any request clears the latch
    p_wel_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_req |=> !sr_rdata[POS_WEL]);

    // R2: a lone enable command sets the latch
    p_wen_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_cmd && !wdis_cmd && !sr_wr_req) |=> sr_rdata[POS_WEL]);

    // R6: hardware protection refuses the request
    p_protect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_req && sr_rdata[POS_LOCK] && !sr_rdata[POS_QEN] && !wp_sync_n) |=> wr_err);

    // R8: unlocked register with latch set accepts
    p_unlocked_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_req && sr_rdata[POS_WEL] && !sr_rdata[POS_LOCK]) |=> !wr_err);
endmodule

bind sreg_guard sreg_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wen_cmd   (wen_cmd),
    .wdis_cmd  (wdis_cmd),
    .sr_wr_req (sr_wr_req),
    .sr_rdata  (sr_rdata),
    .wr_err    (wr_err),
    .wp_sync_n (wp_sync_n)
);

// File: tb/sim_sreg_guard.sv
module sim_sreg_guard;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wen_cmd = 1'b0;
    logic       wdis_cmd = 1'b0;
    logic       sr_wr_req = 1'b0;
    logic [7:0] sr_wdata = 8'h00;
    logic       wp_pin_n = 1'b1;
    logic [7:0] sr_rdata;
    logic       wr_err;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // Reference model state
    bit m_s1, m_s2, m_lock, m_qen, m_wel, m_err;
    bit [3:0] m_bp;

    sreg_guard u0 (
        .clk(clk), .rst_n(rst_n), .wen_cmd(wen_cmd), .wdis_cmd(wdis_cmd),
        .sr_wr_req(sr_wr_req), .sr_wdata(sr_wdata), .wp_pin_n(wp_pin_n),
        .sr_rdata(sr_rdata), .wr_err(wr_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        bit locked, ok;
        started = 1'b1;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_lock = 0; m_qen = 0; m_bp = 0; m_wel = 0; m_err = 0;
        end else begin
            locked = m_lock && !m_qen && !m_s2;
            ok = sr_wr_req && m_wel && !locked;
            m_err = sr_wr_req && !ok;
            if (ok) begin
                m_lock = sr_wdata[7]; m_qen = sr_wdata[6]; m_bp = sr_wdata[5:2];
            end
            if (sr_wr_req) m_wel = 0;
            else if (wdis_cmd) m_wel = 0;
            else if (wen_cmd) m_wel = 1;
            m_s2 = m_s1;
            m_s1 = wp_pin_n;
        end
    end

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (started && !done)
            check("R3/R4 model", {wr_err, sr_rdata}, {m_err, m_lock, m_qen, m_bp, m_wel, 1'b0});
    end

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic cyc(input bit en, input bit dis, input bit req, input logic [7:0] d);
        @(negedge clk);
        wen_cmd = en; wdis_cmd = dis; sr_wr_req = req; sr_wdata = d;
        @(negedge clk);
        wen_cmd = 0; wdis_cmd = 0; sr_wr_req = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pin(input bit v);
        @(negedge clk);
        wp_pin_n = v;
        idle(3);
    endtask

    initial begin
        idle(3);
        check("R1 reset", {wr_err, sr_rdata}, 9'h000);
        rst_n = 1;

        cyc(0, 0, 1, 8'hFC);
        check("R4 no latch", {wr_err, sr_rdata}, 9'h100);
        idle(1);
        check("R11 err single", {8'h00, wr_err}, 9'h000);

        cyc(1, 0, 0, 8'h00);
        check("R2 set", {1'b0, sr_rdata}, 9'h002);
        cyc(0, 1, 0, 8'h00);
        check("R2 clear", {1'b0, sr_rdata}, 9'h000);
        cyc(1, 1, 0, 8'h00);
        check("R2 both", {1'b0, sr_rdata}, 9'h000);

        cyc(1, 0, 0, 8'h00);
        cyc(0, 0, 1, 8'h3D);
        check("R3 commit", {wr_err, sr_rdata}, 9'h03C);
        check("R5 cleared", {8'h00, sr_rdata[1]}, 9'h000);

        pin(0);
        cyc(1, 0, 0, 8'h00);
        cyc(0, 0, 1, 8'h14);
        check("R8 pin low", {wr_err, sr_rdata}, 9'h014);
        cyc(1, 0, 0, 8'h00);
        cyc(0, 0, 1, 8'h94);
        check("R8 set lock", {wr_err, sr_rdata}, 9'h094);
        cyc(1, 0, 0, 8'h00);
        cyc(0, 0, 1, 8'h00);
        check("R6 locked", {wr_err, sr_rdata}, 9'h194);

        // R10: pin rises with the enable; request at second edge still sees low
        @(negedge clk);
        wp_pin_n = 1; wen_cmd = 1;
        @(negedge clk);
        wen_cmd = 0; sr_wr_req = 1; sr_wdata = 8'h80;
        @(negedge clk);
        sr_wr_req = 0;
        check("R10 sync delay", {wr_err, sr_rdata}, 9'h194);
        cyc(1, 0, 0, 8'h00);
        cyc(0, 0, 1, 8'h84);
        check("R7 pin high", {wr_err, sr_rdata}, 9'h084);

        cyc(1, 0, 0, 8'h00);
        cyc(0, 0, 1, 8'hC4);
        check("R9 set qen", {wr_err, sr_rdata}, 9'h0C4);
        pin(0);
        cyc(1, 0, 0, 8'h00);
        cyc(0, 0, 1, 8'hC0);
        check("R9 pin ignored", {wr_err, sr_rdata}, 9'h0C0);
        cyc(1, 0, 0, 8'h00);
        cyc(0, 0, 1, 8'h80);
        check("R9 clear qen", {wr_err, sr_rdata}, 9'h080);
        cyc(1, 0, 0, 8'h00);
        cyc(0, 0, 1, 8'h00);
        check("R6 relocked", {wr_err, sr_rdata}, 9'h180);

        pin(1);
        cyc(1, 0, 1, 8'h00);
        check("R5 req with enable", {wr_err, sr_rdata}, 9'h180);
        idle(1);
        check("R5 latch stays clear", {wr_err, sr_rdata}, 9'h080);

        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        check("R1 mid reset", {wr_err, sr_rdata}, 9'h000);
        rst_n = 1;
        idle(2);
        finish_run();
    end
endmodule